// File: doc/BRIEF.md
# Parallel Control Register Bank

This block holds a bank of byte-wide control registers that the display pipeline reads all at once. Every register is visible at every moment on one wide output vector, so timing generators, address generators and pixel logic can each tap the bytes they need without an arbitrated read path. The host side loads the bank through a single byte write port made of a write strobe, a 20-bit byte address and 8 bits of data.

The bank answers to a window of the address space. The window is as large as the bank, a power of two of at least 256 bytes. A write is taken only when the address bits above the index field equal the same bits of the base-address parameter. The bits below that boundary pick the register. Every input, reset included, passes through a capture register before it is used. This shortens the paths from the write source and lets the bank run from a slower clock.

Reset loads the first 32 registers from a parameter image and clears all the others.

Top module: `ctrl_bank`

## Requirements
- R1: Once reset has been taken, register n for n in 0..31 holds byte n of the INIT_IMAGE parameter (bits [8n+7:8n]). Every register from 32 up to NUM_REGS-1 holds 0.
- R2: Register n drives bits [8n+7:8n] of `regs_out`, with bit 0 of the register on the lower bit.
- R3: A write with `wr_en` high is accepted when `wr_addr[19:K]` equals `WIN_BASE[19:K]`, where K = log2(NUM_REGS). With the default 256 registers, K is 8. The accepted write stores `wr_data` in register `wr_addr[K-1:0]`.
- R4: An accepted write reaches `regs_out` on the second rising clock edge after it is presented. After the first edge the output still shows the old value.
- R5: While `wr_en` is low, no register changes, whatever the address and data.
- R6: A write whose upper address bits differ from the base changes no register. This holds even when only one bit differs, including the bit just above the index field.
- R7: `rst` is captured before use. The rising edge that first samples `rst` high leaves the registers unchanged, and the following edge applies the reset image. A write presented together with that first reset cycle is discarded.
- R8: An accepted write changes only its target byte. Writes on back-to-back cycles all land, and the later write to the same register wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, captured before use |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 20 | Byte address of the write |
| wr_data | input | 8 | Byte to be written |
| regs_out | output | NUM_REGS*8 | All registers in parallel; register n at [8n+7:8n] |

## Verification
A fault in the capture stage or the window decode shows up two cycles after the offending write: a byte changes where none should, or the addressed byte stays at its old value. The bench compares the whole output vector every cycle against a model, so any stray or missing byte update is seen within those two cycles. A wrong reset image or a wrong reset delay is visible on the second edge after reset rises. Latency faults are caught by sampling the output one edge after a write as well as two edges after it.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int CR_ADDR_W     = 20;
    localparam int CR_DATA_W     = 8;
    localparam int CR_INIT_BYTES = 32;

    // captured copy of the write port
    typedef struct packed {
        logic                 en;
        logic [CR_ADDR_W-1:0] addr;
        logic [CR_DATA_W-1:0] data;
    } cr_wr_t;

    // decoded write: index is full width, upper bits unused
    typedef struct packed {
        logic                 hit;
        logic [CR_ADDR_W-1:0] idx;
        logic [CR_DATA_W-1:0] data;
    } cr_dec_t;

    function automatic logic [CR_INIT_BYTES*CR_DATA_W-1:0] default_image();
        logic [CR_INIT_BYTES*CR_DATA_W-1:0] img;
        img = '0;
        for (int i = 0; i < CR_INIT_BYTES; i++) begin
            img[i*CR_DATA_W +: CR_DATA_W] = CR_DATA_W'(8'h80 | i);
        end
        return img;
    endfunction

endpackage

// File: rtl/cr_input_stage.sv
module cr_input_stage
    import cr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CR_ADDR_W-1:0] wr_addr,
    input  logic [CR_DATA_W-1:0] wr_data,
    output logic                 rst_q,
    output cr_wr_t               cap
);

    // every input, reset included, is flopped before use
    always_ff @(posedge clk) begin
        rst_q     <= rst;
        cap.en    <= wr_en;
        cap.addr  <= wr_addr;
        cap.data  <= wr_data;
    end

endmodule

// File: rtl/cr_window_decode.sv
module cr_window_decode
    import cr_pkg::*;
#(
    parameter int                   NUM_REGS = 256,
    parameter logic [CR_ADDR_W-1:0] WIN_BASE = 20'h03F00
) (
    input  cr_wr_t              cap,
    output cr_dec_t             dec,
    output logic [NUM_REGS-1:0] sel
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int TAG_W = CR_ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag_in;
    logic [TAG_W-1:0] tag_base;
    logic [IDX_W-1:0] idx;

    // equality on the bits above the index field only
    assign tag_in   = cap.addr[CR_ADDR_W-1:IDX_W];
    assign tag_base = WIN_BASE[CR_ADDR_W-1:IDX_W];
    assign idx      = cap.addr[IDX_W-1:0];

    always_comb begin
        dec.hit  = cap.en && (tag_in == tag_base);
        dec.idx  = CR_ADDR_W'(idx);
        dec.data = cap.data;
    end

    for (genvar n = 0; n < NUM_REGS; n++) begin : g_sel
        assign sel[n] = dec.hit && (idx == IDX_W'(n));
    end

endmodule

// File: rtl/cr_reg_array.sv
module cr_reg_array
    import cr_pkg::*;
#(
    parameter int                                 NUM_REGS   = 256,
    parameter logic [CR_INIT_BYTES*CR_DATA_W-1:0] INIT_IMAGE = default_image()
) (
    input  logic                          clk,
    input  logic                          rst_q,
    input  logic [NUM_REGS-1:0]           sel,
    input  logic [CR_DATA_W-1:0]          wdata,
    output logic [NUM_REGS*CR_DATA_W-1:0] regs_out
);

    for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
        logic [CR_DATA_W-1:0] rst_val;
        logic [CR_DATA_W-1:0] q;

        if (n < CR_INIT_BYTES) begin : g_init
            assign rst_val = INIT_IMAGE[n*CR_DATA_W +: CR_DATA_W];
        end else begin : g_zero
            assign rst_val = '0;
        end

        always_ff @(posedge clk) begin
            if (rst_q) begin
                q <= rst_val;
            end else if (sel[n]) begin
                q <= wdata;
            end
        end

        assign regs_out[n*CR_DATA_W +: CR_DATA_W] = q;
    end

endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank
    import cr_pkg::*;
#(
    parameter int                                 NUM_REGS   = 256,
    parameter logic [CR_ADDR_W-1:0]               WIN_BASE   = 20'h03F00,
    parameter logic [CR_INIT_BYTES*CR_DATA_W-1:0] INIT_IMAGE = default_image()
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [CR_ADDR_W-1:0]          wr_addr,
    input  logic [CR_DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*CR_DATA_W-1:0] regs_out
);

    logic                 rst_q;
    cr_wr_t               cap;
    cr_dec_t              dec;
    logic [NUM_REGS-1:0]  sel;

    // flat views for the bound checker
    logic                 dec_hit;
    logic [CR_ADDR_W-1:0] dec_idx;
    logic [CR_DATA_W-1:0] dec_data;

    cr_input_stage u_in (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rst_q   (rst_q),
        .cap     (cap)
    );

    cr_window_decode #(
        .NUM_REGS (NUM_REGS),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .cap (cap),
        .dec (dec),
        .sel (sel)
    );

    cr_reg_array #(
        .NUM_REGS   (NUM_REGS),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_arr (
        .clk      (clk),
        .rst_q    (rst_q),
        .sel      (sel),
        .wdata    (dec.data),
        .regs_out (regs_out)
    );

    assign dec_hit  = dec.hit;
    assign dec_idx  = dec.idx;
    assign dec_data = dec.data;

endmodule

// File: rtl/ctrl_bank_chk.sv
module ctrl_bank_chk
    import cr_pkg::*;
#(
    parameter int                                 NUM_REGS   = 256,
    parameter logic [CR_INIT_BYTES*CR_DATA_W-1:0] INIT_IMAGE = default_image()
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          rst_q,
    input logic                          dec_hit,
    input logic [CR_ADDR_W-1:0]          dec_idx,
    input logic [CR_DATA_W-1:0]          dec_data,
    input logic [NUM_REGS*CR_DATA_W-1:0] regs_out
);

    logic                 started = 1'b0;
    logic [CR_ADDR_W-1:0] idx_d;
    logic [CR_DATA_W-1:0] data_d;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        idx_d   <= dec_idx;
        data_d  <= dec_data;
    end

    function automatic logic [NUM_REGS*CR_DATA_W-1:0] reset_image();
        logic [NUM_REGS*CR_DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < CR_INIT_BYTES; i++) begin
            v[i*CR_DATA_W +: CR_DATA_W] = INIT_IMAGE[i*CR_DATA_W +: CR_DATA_W];
        end
        return v;
    endfunction

    function automatic int changed_bytes(logic [NUM_REGS*CR_DATA_W-1:0] a,
                                         logic [NUM_REGS*CR_DATA_W-1:0] b);
        int c;
        c = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (a[i*CR_DATA_W +: CR_DATA_W] != b[i*CR_DATA_W +: CR_DATA_W]) c++;
        end
        return c;
    endfunction

    // R7: the internal reset follows the reset pin by one clock
    assert_rst_capture_R7: assert property (@(posedge clk) disable iff (!started)
        started |=> (rst_q == $past(rst)));

    // R1: a captured reset yields the reset image on the next edge
    assert_reset_image_R1: assert property (@(posedge clk) disable iff (!started)
        rst_q |=> (regs_out == reset_image()));

    // R5, R6: no accepted write means the bank holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (!started || rst_q)
        !dec_hit |=> $stable(regs_out));

    // R3: accepted write stores its byte at its index
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!started || rst_q)
        dec_hit |=> (regs_out[idx_d[$clog2(NUM_REGS)-1:0]*CR_DATA_W +: CR_DATA_W] == data_d));

    // R8: at most one byte changes per cycle outside reset
    assert_one_byte_R8: assert property (@(posedge clk) disable iff (!started || rst_q)
        started |=> (changed_bytes(regs_out, $past(regs_out)) <= 1));

endmodule

bind ctrl_bank ctrl_bank_chk #(
    .NUM_REGS   (NUM_REGS),
    .INIT_IMAGE (INIT_IMAGE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_q    (rst_q),
    .dec_hit  (dec_hit),
    .dec_idx  (dec_idx),
    .dec_data (dec_data),
    .regs_out (regs_out)
);

// File: tb/ctrl_bank_tb.sv
module ctrl_bank_tb;

    localparam int          NREG  = 256;
    localparam int          KBITS = 8;
    localparam logic [19:0] BASE  = 20'h03F00;

    function automatic logic [255:0] tb_image();
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'((i * 37 + 11) & 8'hFF);
        return v;
    endfunction

    localparam logic [255:0] IMG = tb_image();

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [19:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [NREG*8-1:0] regs_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] mdl [NREG];

    typedef struct packed { logic en; logic [19:0] addr; logic [7:0] data; } op_t;
    op_t p1, p2;

    always #5 clk = ~clk;

    ctrl_bank #(
        .NUM_REGS   (NREG),
        .WIN_BASE   (BASE),
        .INIT_IMAGE (IMG)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_out (regs_out)
    );

    function automatic logic is_hit(op_t o);
        return o.en && (o.addr[19:KBITS] == BASE[19:KBITS]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) mdl[i] = (i < 32) ? IMG[i*8 +: 8] : 8'h00;
    endtask

    task automatic model_apply(op_t o);
        if (is_hit(o)) mdl[o.addr[KBITS-1:0]] = o.data;
    endtask

    task automatic chk_byte(string tag, int idx, logic [7:0] exp);
        n_tests++;
        if (regs_out[idx*8 +: 8] !== exp) begin
            n_fail++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, regs_out[idx*8 +: 8], exp);
        end
    endtask

    task automatic chk_all(string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs_out[i*8 +: 8] !== mdl[i]) bad = i;
        n_tests++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, bad, regs_out[bad*8 +: 8], mdl[bad]);
        end
    endtask

    task automatic drive(op_t o);
        wr_en   = o.en;
        wr_addr = o.addr;
        wr_data = o.data;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic op_t mk(logic en, logic [19:0] a, logic [7:0] d);
        op_t o;
        o.en = en; o.addr = a; o.data = d;
        return o;
    endfunction

    localparam op_t IDLE = '0;

    // one pipelined cycle: output now reflects the op driven two steps ago
    task automatic pipe(op_t o, string tag);
        step();
        model_apply(p2);
        chk_all(tag);
        p2 = p1;
        p1 = o;
        drive(o);
    endtask

    initial begin : main
        void'($urandom(32'd4242));
        p1 = IDLE; p2 = IDLE;
        repeat (4) step();
        model_reset();
        chk_all("R1 reset image");
        chk_byte("R1 init byte 31", 31, IMG[31*8 +: 8]);
        chk_byte("R1 byte 32 zero", 32, 8'h00);
        rst = 1'b0;
        repeat (3) step();
        chk_all("R1 after release");

        // R4: latency, old value after one edge, new after two
        drive(mk(1'b1, BASE | 20'h40, 8'h5A));
        step(); drive(IDLE);
        chk_byte("R4 one edge old", 64, 8'h00);
        step();
        chk_byte("R4 two edges new", 64, 8'h5A);
        mdl[64] = 8'h5A;

        // R2: field positions at both ends
        drive(mk(1'b1, BASE | 20'h00, 8'hC1)); step();
        drive(mk(1'b1, BASE | 20'hFF, 8'h3E)); step();
        drive(IDLE); step(); step();
        mdl[0] = 8'hC1; mdl[255] = 8'h3E;
        n_tests++;
        if (regs_out[7:0] !== 8'hC1 || regs_out[NREG*8-1 -: 8] !== 8'h3E) begin
            n_fail++;
            $display("FAIL R2 layout: actual %h/%h expected c1/3e", regs_out[7:0], regs_out[NREG*8-1 -: 8]);
        end

        // R5: enable low ignored
        drive(mk(1'b0, BASE | 20'h10, 8'hEE)); step();
        drive(IDLE); step(); step();
        chk_all("R5 enable low");

        // R6: one-bit miss just above index, and top bit
        drive(mk(1'b1, BASE ^ 20'h00100, 8'h77)); step();
        drive(mk(1'b1, BASE ^ 20'h80000, 8'h78)); step();
        drive(IDLE); step(); step();
        chk_all("R6 address miss");

        // R8: back-to-back, same register last wins
        drive(mk(1'b1, BASE | 20'h20, 8'h11)); step();
        drive(mk(1'b1, BASE | 20'h21, 8'h22)); step();
        drive(mk(1'b1, BASE | 20'h20, 8'h33)); step();
        drive(IDLE); step(); step();
        mdl[32] = 8'h33; mdl[33] = 8'h22;
        chk_byte("R8 last wins", 32, 8'h33);
        chk_all("R8 back to back");

        // random mix
        p1 = IDLE; p2 = IDLE;
        for (int k = 0; k < 3000; k++) begin
            op_t o;
            int sel;
            sel = $urandom_range(0, 9);
            o.en   = ($urandom_range(0, 4) != 0);
            o.data = 8'($urandom);
            if (sel < 6)
                o.addr = BASE | 20'($urandom_range(0, NREG - 1));
            else if (sel < 9)
                o.addr = (BASE ^ (20'h1 << $urandom_range(KBITS, 19))) | 20'($urandom_range(0, NREG - 1));
            else
                o.addr = 20'($urandom);
            pipe(o, "R3 random stream");
        end
        pipe(IDLE, "R3 drain");
        pipe(IDLE, "R3 drain");
        pipe(IDLE, "R3 drain");

        // R7: captured reset, write during first reset cycle lost
        mdl[5] = IMG[5*8 +: 8];
        drive(mk(1'b1, BASE | 20'h28, 8'hC3)); step();
        drive(IDLE); step(); step();
        chk_byte("R7 setup", 40, 8'hC3);
        rst = 1'b1;
        drive(mk(1'b1, BASE | 20'h05, 8'h55));
        step();
        drive(IDLE);
        chk_byte("R7 first edge holds", 40, 8'hC3);
        step();
        model_reset();
        chk_all("R1 reset image again");
        rst = 1'b0;
        repeat (3) step();
        chk_byte("R7 write in reset lost", 5, IMG[5*8 +: 8]);
        chk_all("R7 after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule